// File: doc/BRIEF.md
# Mixed-Width True Dual-Port RAM

A 32-Kbit storage block with two ports that run on separate clocks and work independently: each port has its own chip select, write enable, address, write data and read data. By parameter, each port sees the array either as 2048 words of 16 bits or as 4096 bytes, and the two ports may pick different views of the same contents. A byte written through a narrow port reads back in the correct half of the word through a wide port, and the reverse also holds.

A wide port can update a single byte lane of a word. A narrow port uses its byte-select pin as the lowest bit of a 12-bit byte address. Each port has its own parameters for an optional output register, which adds one cycle of read latency and comes with a load enable and a synchronous clear, and for the output behaviour during a write cycle: hold the previous value, or show the data just written.

Top module: `mw_dpram`

## Requirements
- R1: The array holds 2048 words of 16 bits. On a 16-bit port the 11-bit address selects the word, and every address from 0 to 2047 is usable.
- R2: On an 8-bit port the byte address is {addr, bsel}. bsel=0 selects bits [7:0] of word addr and bsel=1 selects bits [15:8], so data crosses between 8-bit and 16-bit ports in both directions without reordering.
- R3: On a 16-bit port, a write with lane_en=1 changes only bits [15:8] when bsel=1 and only bits [7:0] when bsel=0. A write with lane_en=0 changes all 16 bits.
- R4: With cs low a port neither reads nor writes, whatever we and the other inputs carry, and its read data holds its value.
- R5: With cs=1 and we=0 a port reads. Without the output register the word is on dout after the read clock edge. With the output register it appears after the next edge at which oce is 1.
- R6: The output register loads only on an edge where oce is 1. When a port has no output register, its oce and oclr inputs have no effect on dout.
- R7: oclr=1 at a clock edge clears the registered dout to zero, whatever the value of oce.
- R8: In normal mode a write cycle leaves the writing port's read data at its previous value.
- R9: In write-through mode, after the write edge the writing port's dout shows the written data: the whole updated word on a 16-bit port, or the written byte on an 8-bit port.
- R10: An 8-bit port always drives dout[15:8] as zero and ignores din[15:8] and lane_en.
- R11: When one port reads an address in the same cycle that the other port writes it, the read returns either the old data or the new data, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock, rising edge |
| cs_a | input | 1 | Port A select, active high |
| we_a | input | 1 | Port A 1 = write, 0 = read |
| addr_a | input | 11 | Port A word address |
| bsel_a | input | 1 | Port A byte lane / low byte-address bit |
| lane_en_a | input | 1 | Port A single-lane write enable (16-bit mode) |
| din_a | input | 16 | Port A write data |
| oce_a | input | 1 | Port A output register load enable |
| oclr_a | input | 1 | Port A output register synchronous clear |
| dout_a | output | 16 | Port A read data |
| clk_b | input | 1 | Port B clock, rising edge |
| cs_b | input | 1 | Port B select, active high |
| we_b | input | 1 | Port B 1 = write, 0 = read |
| addr_b | input | 11 | Port B word address |
| bsel_b | input | 1 | Port B byte lane / low byte-address bit |
| lane_en_b | input | 1 | Port B single-lane write enable (16-bit mode) |
| din_b | input | 16 | Port B write data |
| oce_b | input | 1 | Port B output register load enable |
| oclr_b | input | 1 | Port B output register synchronous clear |
| dout_b | output | 16 | Port B read data |

## Verification
The bench uses a wide registered port in normal mode together with a narrow unregistered port in write-through mode, and it aims at the places where lanes and timing can slip. Bytes are written narrow and read wide, and written wide and read narrow; a swapped lane mapping shows up as bytes in reversed order. Lane-masked writes and narrow writes with junk in the upper data bits are checked, so a mask that writes all 16 bits corrupts the neighbouring byte. Other tests read back-to-back and hold oce low to find an output stage with the wrong latency or one that ignores its enable. Still others deselect a port with write enable high, clear the output register while oce is low, and write through a port at the highest address. These catch a port that writes when cs is low, a clear that waits for oce, and a write path that updates dout in the wrong mode.

// File: rtl/mwdp_pkg.sv
`timescale 1ns/1ps
// Package mwdp_pkg: geometry of the shared array, the per-port request
// record passed from the decoder to storage and output stage, and the
// byte-merge helper. Assumes a two-lane word (WORD_W = 2 * LANE_W).
package mwdp_pkg;
    localparam int ADDR_W  = 11;
    localparam int LANE_W  = 8;
    localparam int WORD_W  = 2 * LANE_W;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam logic [WORD_W-1:0] MASK_LO = {{LANE_W{1'b0}}, {LANE_W{1'b1}}};
    localparam logic [WORD_W-1:0] MASK_HI = {{LANE_W{1'b1}}, {LANE_W{1'b0}}};

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] word;
        logic              lane;
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] data;
    } mwdp_req_t;

    // Replace the masked bits of a stored word with new data.
    function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] old_w,
                                                     input logic [WORD_W-1:0] mask,
                                                     input logic [WORD_W-1:0] data);
        return (old_w & ~mask) | (data & mask);
    endfunction
endpackage

// File: rtl/mwdp_req_decode.sv
`timescale 1ns/1ps
// Module mwdp_req_decode: turns one port's raw pins into a request record
// (read/write strobe, word index, lane, write mask and lane-replicated data).
// Assumes PORT_W is LANE_W or WORD_W. In the narrow view the byte address
// is {addr, bsel}, so the word index equals addr and bsel picks the lane.
module mwdp_req_decode
    import mwdp_pkg::*;
#(
    parameter int PORT_W = 16
) (
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bsel,
    input  logic              lane_en,
    input  logic [WORD_W-1:0] din,
    output mwdp_req_t         req
);
    logic [WORD_W-1:0] mask_w;
    logic [WORD_W-1:0] data_w;
    logic [WORD_W-1:0] lane_mask;

    // Mask of the single lane named by bsel.
    assign lane_mask = bsel ? MASK_HI : MASK_LO;

    generate
        if (PORT_W == LANE_W) begin : g_narrow
            logic unused_narrow;
            // Narrow view: always one lane, low byte copied to both lanes.
            assign mask_w = lane_mask;
            assign data_w = {2{din[LANE_W-1:0]}};
            assign unused_narrow = ^{din[WORD_W-1:LANE_W], lane_en};
        end else begin : g_wide
            // Wide view: one lane when lane_en is set, else the whole word.
            assign mask_w = lane_en ? lane_mask : {WORD_W{1'b1}};
            assign data_w = din;
        end
    endgenerate

    // Assemble the request record.
    always_comb begin
        req.rd   = cs & ~we;
        req.wr   = cs & we;
        req.word = addr;
        req.lane = bsel;
        req.mask = mask_w;
        req.data = data_w;
    end
endmodule

// File: rtl/mwdp_xor_store.sv
`timescale 1ns/1ps
// Module mwdp_xor_store: the shared array, kept as two banks that each have
// a single writer (port A or port B). The stored word is the XOR of the two
// banks, so each port's write process owns its own bank. Assumes the two
// ports never write the same word in the same cycle; if they do, the
// contents are undefined. Contents start at zero.
module mwdp_xor_store
    import mwdp_pkg::*;
(
    input  logic              clk_a,
    input  mwdp_req_t         req_a,
    input  logic              clk_b,
    input  mwdp_req_t         req_b,
    output logic [WORD_W-1:0] old_a,
    output logic [WORD_W-1:0] old_b
);
    logic [WORD_W-1:0] bank_a [DEPTH];
    logic [WORD_W-1:0] bank_b [DEPTH];
    logic              unused_req;

    // Start from a known all-zero content so the XOR never carries unknowns.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            bank_a[i] = '0;
            bank_b[i] = '0;
        end
    end

    // Current word seen by each port.
    assign old_a = bank_a[req_a.word] ^ bank_b[req_a.word];
    assign old_b = bank_a[req_b.word] ^ bank_b[req_b.word];

    // Port A write: store the merged word pre-cancelled by bank B.
    always_ff @(posedge clk_a) begin
        if (req_a.wr)
            bank_a[req_a.word] <= merge_word(old_a, req_a.mask, req_a.data) ^ bank_b[req_a.word];
    end

    // Port B write: store the merged word pre-cancelled by bank A.
    always_ff @(posedge clk_b) begin
        if (req_b.wr)
            bank_b[req_b.word] <= merge_word(old_b, req_b.mask, req_b.data) ^ bank_a[req_b.word];
    end

    assign unused_req = ^{req_a.rd, req_a.lane, req_b.rd, req_b.lane};
endmodule

// File: rtl/mwdp_port_out.sv
`timescale 1ns/1ps
// Module mwdp_port_out: read path of one port. A capture register takes
// the addressed word (or lane) on a read, and on a write when WTHRU is set.
// An optional output register with load enable and synchronous active-high
// clear follows it. Assumes old_word is the array word for req.word,
// valid before the clock edge.
module mwdp_port_out
    import mwdp_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter bit OUTREG = 1'b0,
    parameter bit WTHRU  = 1'b0
) (
    input  logic              clk,
    input  mwdp_req_t         req,
    input  logic [WORD_W-1:0] old_word,
    input  logic              oce,
    input  logic              oclr,
    output logic [WORD_W-1:0] dout
);
    logic [WORD_W-1:0] cap;
    logic              unused_word;

    // Present a word in the port's view: whole word, or one lane zero-extended.
    function automatic logic [WORD_W-1:0] view(input logic [WORD_W-1:0] w, input logic lane);
        if (PORT_W == LANE_W)
            return {{LANE_W{1'b0}}, (lane ? w[WORD_W-1:LANE_W] : w[LANE_W-1:0])};
        else
            return w;
    endfunction

    // Capture read data, or the freshly written data in write-through mode.
    always_ff @(posedge clk) begin
        if (req.rd)
            cap <= view(old_word, req.lane);
        else if (req.wr && WTHRU)
            cap <= view(merge_word(old_word, req.mask, req.data), req.lane);
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) (!req.rd && !req.wr) |=> $stable(cap)); // R4

    generate
        if (!WTHRU) begin : g_normal
            AST_NORMAL_HOLD: assert property (@(posedge clk) req.wr |=> $stable(cap)); // R8
        end
        if (PORT_W == LANE_W) begin : g_narrow_chk
            AST_NARROW_HI: assert property (@(posedge clk) req.rd |=> (cap[WORD_W-1:LANE_W] == '0)); // R10
        end
        if (OUTREG) begin : g_oreg
            logic [WORD_W-1:0] oreg;
            // Output register: clear wins, otherwise load when enabled.
            always_ff @(posedge clk) begin
                if (oclr)
                    oreg <= '0;
                else if (oce)
                    oreg <= cap;
            end
            assign dout = oreg;

            AST_CLR_ZERO: assert property (@(posedge clk) oclr |=> (oreg == '0)); // R7
            AST_OCE_HOLD: assert property (@(posedge clk) (!oce && !oclr) |=> $stable(oreg)); // R6
        end else begin : g_direct
            logic unused_oreg_pins;
            assign dout = cap;
            assign unused_oreg_pins = ^{oce, oclr};
        end
    endgenerate

    assign unused_word = ^req.word;
endmodule

// File: rtl/mw_dpram.sv
`timescale 1ns/1ps
// Module mw_dpram: 32-Kbit true dual-port RAM whose two ports each see the
// array as 2048x16 or 4096x8 (WIDTH_x = 16 or 8), with an optional output
// register (OUTREG_x) and a normal or write-through mode (WTHRU_x) per port.
// Assumes the clocks are independent and that same-word writes from both
// ports in one cycle do not happen.
module mw_dpram
    import mwdp_pkg::*;
#(
    parameter int WIDTH_A  = 16,
    parameter bit OUTREG_A = 1'b1,
    parameter bit WTHRU_A  = 1'b0,
    parameter int WIDTH_B  = 8,
    parameter bit OUTREG_B = 1'b0,
    parameter bit WTHRU_B  = 1'b1
) (
    input  logic              clk_a,
    input  logic              cs_a,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic              bsel_a,
    input  logic              lane_en_a,
    input  logic [WORD_W-1:0] din_a,
    input  logic              oce_a,
    input  logic              oclr_a,
    output logic [WORD_W-1:0] dout_a,
    input  logic              clk_b,
    input  logic              cs_b,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              bsel_b,
    input  logic              lane_en_b,
    input  logic [WORD_W-1:0] din_b,
    input  logic              oce_b,
    input  logic              oclr_b,
    output logic [WORD_W-1:0] dout_b
);
    mwdp_req_t         req_a, req_b;
    logic [WORD_W-1:0] old_a, old_b;

    mwdp_req_decode #(.PORT_W(WIDTH_A)) u_dec_a (
        .cs(cs_a), .we(we_a), .addr(addr_a), .bsel(bsel_a),
        .lane_en(lane_en_a), .din(din_a), .req(req_a)
    );

    mwdp_req_decode #(.PORT_W(WIDTH_B)) u_dec_b (
        .cs(cs_b), .we(we_b), .addr(addr_b), .bsel(bsel_b),
        .lane_en(lane_en_b), .din(din_b), .req(req_b)
    );

    mwdp_xor_store u_store (
        .clk_a(clk_a), .req_a(req_a), .clk_b(clk_b), .req_b(req_b),
        .old_a(old_a), .old_b(old_b)
    );

    mwdp_port_out #(.PORT_W(WIDTH_A), .OUTREG(OUTREG_A), .WTHRU(WTHRU_A)) u_out_a (
        .clk(clk_a), .req(req_a), .old_word(old_a),
        .oce(oce_a), .oclr(oclr_a), .dout(dout_a)
    );

    mwdp_port_out #(.PORT_W(WIDTH_B), .OUTREG(OUTREG_B), .WTHRU(WTHRU_B)) u_out_b (
        .clk(clk_b), .req(req_b), .old_word(old_b),
        .oce(oce_b), .oclr(oclr_b), .dout(dout_b)
    );
endmodule

// File: tb/mw_dpram_tb.sv
`timescale 1ns/1ps
// Directed bench: port A is 16-bit, registered, normal mode; port B is
// 8-bit, unregistered, write-through. Both ports share one 200 MHz clock.
module mw_dpram_tb;
    logic        clk = 1'b0;
    logic        cs_a = 0, we_a = 0, bsel_a = 0, lane_en_a = 0, oce_a = 1, oclr_a = 0;
    logic [10:0] addr_a = '0;
    logic [15:0] din_a = '0;
    logic [15:0] dout_a;
    logic        cs_b = 0, we_b = 0, bsel_b = 0, lane_en_b = 0, oce_b = 1, oclr_b = 0;
    logic [10:0] addr_b = '0;
    logic [15:0] din_b = '0;
    logic [15:0] dout_b;
    int          n_checks = 0;
    int          n_errors = 0;

    always #2.5 clk = ~clk;

    mw_dpram #(.WIDTH_A(16), .OUTREG_A(1'b1), .WTHRU_A(1'b0),
               .WIDTH_B(8), .OUTREG_B(1'b0), .WTHRU_B(1'b1)) u_dut (
        .clk_a(clk), .cs_a(cs_a), .we_a(we_a), .addr_a(addr_a), .bsel_a(bsel_a),
        .lane_en_a(lane_en_a), .din_a(din_a), .oce_a(oce_a), .oclr_a(oclr_a), .dout_a(dout_a),
        .clk_b(clk), .cs_b(cs_b), .we_b(we_b), .addr_b(addr_b), .bsel_b(bsel_b),
        .lane_en_b(lane_en_b), .din_b(din_b), .oce_b(oce_b), .oclr_b(oclr_b), .dout_b(dout_b)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Port A: one write edge; returns at the following falling edge.
    task automatic a_write(input logic [10:0] ad, input logic [15:0] d, input logic le, input logic bs);
        @(negedge clk); cs_a = 1; we_a = 1; addr_a = ad; din_a = d; lane_en_a = le; bsel_a = bs;
        @(negedge clk); cs_a = 0; we_a = 0; lane_en_a = 0;
    endtask

    // Port A: read edge, then output-register edge; returns just after it.
    task automatic a_read(input logic [10:0] ad);
        @(negedge clk); cs_a = 1; we_a = 0; addr_a = ad;
        @(negedge clk); cs_a = 0;
        @(posedge clk); #1;
    endtask

    // Port B: one write edge; returns at the following falling edge.
    task automatic b_write(input logic [10:0] ad, input logic bs, input logic [15:0] d, input logic le);
        @(negedge clk); cs_b = 1; we_b = 1; addr_b = ad; bsel_b = bs; din_b = d; lane_en_b = le;
        @(negedge clk); cs_b = 0; we_b = 0; lane_en_b = 0;
    endtask

    // Port B: one read edge; data valid on return.
    task automatic b_read(input logic [10:0] ad, input logic bs);
        @(negedge clk); cs_b = 1; we_b = 0; addr_b = ad; bsel_b = bs;
        @(negedge clk); cs_b = 0;
    endtask

    task automatic t_clear();
        @(negedge clk); oclr_a = 1; oce_a = 0;
        @(negedge clk); oclr_a = 0; oce_a = 1;
        check("R7 clear with oce low", dout_a, 16'h0000);
    endtask

    task automatic t_full_word();
        a_write(11'd5, 16'h1234, 0, 0);
        a_write(11'd7, 16'hABCD, 0, 0);
        a_read(11'd5);
        check("R1 full word read", dout_a, 16'h1234);
        @(negedge clk); cs_a = 1; we_a = 0; addr_a = 11'd7;
        @(posedge clk); #1;
        check("R5 registered port one edge after read", dout_a, 16'h1234);
        @(negedge clk); cs_a = 0;
        @(posedge clk); #1;
        check("R5 registered port two edges after read", dout_a, 16'hABCD);
        a_write(11'd2047, 16'hF00D, 0, 0);
        a_read(11'd2047);
        check("R1 top address", dout_a, 16'hF00D);
        b_read(11'd2047, 1);
        check("R1 top address narrow", dout_b, 16'h00F0);
    endtask

    task automatic t_lanes();
        a_write(11'd16, 16'hAAAA, 0, 0);
        a_write(11'd16, 16'h12FF, 1, 1);
        a_read(11'd16);
        check("R3 upper lane write", dout_a, 16'h12AA);
        a_write(11'd16, 16'h5534, 1, 0);
        a_read(11'd16);
        check("R3 lower lane write", dout_a, 16'h1234);
    endtask

    task automatic t_cross();
        b_write(11'd20, 0, 16'h005A, 0);
        b_write(11'd20, 1, 16'h00C3, 0);
        a_read(11'd20);
        check("R2 narrow write wide read", dout_a, 16'hC35A);
        a_write(11'd30, 16'hBEEF, 0, 0);
        b_read(11'd30, 0);
        check("R2 wide write narrow low", dout_b, 16'h00EF);
        b_read(11'd30, 1);
        check("R10 narrow high byte zero-extended", dout_b, 16'h00BE);
    endtask

    task automatic t_narrow_ignore();
        a_write(11'd40, 16'h1111, 0, 0);
        b_write(11'd40, 1, 16'hFF77, 1);
        a_read(11'd40);
        check("R10 narrow ignores din high and lane_en (upper)", dout_a, 16'h7711);
        b_write(11'd40, 0, 16'hAB22, 1);
        a_read(11'd40);
        check("R10 narrow ignores din high and lane_en (lower)", dout_a, 16'h7722);
    endtask

    task automatic t_cs();
        logic [15:0] prev;
        @(negedge clk); cs_a = 0; we_a = 1; addr_a = 11'd5; din_a = 16'h0000;
        @(negedge clk); we_a = 0;
        a_read(11'd5);
        check("R4 deselected A write ignored", dout_a, 16'h1234);
        prev = dout_b;
        @(negedge clk); cs_b = 0; we_b = 1; addr_b = 11'd30; bsel_b = 0; din_b = 16'h0011;
        @(negedge clk); we_b = 0;
        check("R4 deselected B output held", dout_b, prev);
        b_read(11'd30, 0);
        check("R4 deselected B write ignored", dout_b, 16'h00EF);
    endtask

    task automatic t_normal();
        a_read(11'd5);
        a_write(11'd6, 16'h5555, 0, 0);
        @(posedge clk); #1;
        check("R8 normal mode output held on write", dout_a, 16'h1234);
        a_read(11'd6);
        check("R8 written word stored", dout_a, 16'h5555);
    endtask

    task automatic t_wthru();
        b_write(11'd50, 1, 16'h009C, 0);
        check("R9 write-through upper byte", dout_b, 16'h009C);
        b_write(11'd50, 0, 16'h0033, 0);
        check("R9 write-through lower byte", dout_b, 16'h0033);
        a_read(11'd50);
        check("R2 write-through bytes in place", dout_a, 16'h9C33);
    endtask

    task automatic t_oce();
        logic [15:0] prev;
        a_read(11'd5);
        @(negedge clk); oce_a = 0;
        a_read(11'd7);
        check("R6 oce low holds output", dout_a, 16'h1234);
        @(negedge clk); oce_a = 1;
        @(posedge clk); #1;
        check("R6 oce high loads output", dout_a, 16'hABCD);
        prev = dout_b;
        @(negedge clk); oce_b = 0; oclr_b = 1;
        @(negedge clk); oce_b = 1; oclr_b = 0;
        check("R6 unregistered port ignores oce and oclr", dout_b, prev);
    endtask

    task automatic t_collide();
        a_write(11'd60, 16'h0101, 0, 0);
        @(negedge clk);
        cs_a = 1; we_a = 1; addr_a = 11'd60; din_a = 16'h0202;
        cs_b = 1; we_b = 0; addr_b = 11'd60; bsel_b = 0;
        @(negedge clk); cs_a = 0; we_a = 0; cs_b = 0;
        n_checks++;
        if (dout_b !== 16'h0001 && dout_b !== 16'h0002) begin
            n_errors++;
            $display("FAIL R11 collision read: actual %h expected 0001 or 0002", dout_b);
        end
        a_read(11'd60);
        check("R11 collision write lands", dout_a, 16'h0202);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_clear();
        t_full_word();
        t_lanes();
        t_cross();
        t_narrow_ignore();
        t_cs();
        t_normal();
        t_wthru();
        t_oce();
        t_collide();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule